// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a memory-mapped interval timer. A counter of parameterised width steps down by one on each pulse of a tick enable and raises an interrupt when it underflows. The tick comes from one of two enable inputs, a fast one and a slow one. Both are generated outside the block. Software reaches four word registers over a simple register bus: a load value, the live count, a control word, and an interrupt acknowledge.

The control word gates counting and picks the tick input. It also picks what happens on underflow. In periodic mode the counter refills from the load register. In free-running mode it wraps to all ones. In both modes the interrupt is set and stays set until software acknowledges it. Writing the load register also writes the counter, so the next period starts from the new value. The counter width is set by a parameter, and both 16-bit and 32-bit instances are supported.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset the counter, the load register and the control word are all zero, the interrupt is low and the read data is zero.
- R2: A write to offset 0x00 stores the value, truncated to the counter width, in the load register and also copies it into the counter. Reading 0x00 returns the stored load value.
- R3: While control bit 7 is 0, tick pulses leave the counter unchanged and no interrupt is raised.
- R4: While control bit 7 is 1, the counter decreases by exactly one per selected tick. Control bit 3 = 1 selects `tick_fast` and control bit 3 = 0 selects `tick_slow`. Pulses on the input that is not selected have no effect.
- R5: With control bit 6 = 1 (periodic), a tick that arrives with the counter at zero reloads the counter from the load register and sets the interrupt. A load of N therefore gives one interrupt every N+1 ticks.
- R6: With control bit 6 = 0 (free-running), a tick that arrives with the counter at zero wraps the counter to all ones and sets the interrupt.
- R7: The interrupt stays high across further ticks until a write to offset 0x0C clears it, whatever data that write carries.
- R8: When an underflow and a write to 0x0C fall in the same cycle, the interrupt stays set.
- R9: Clearing control bit 7 drops the interrupt one cycle after the control write takes effect.
- R10: A read has one cycle of latency. Reading 0x04 returns the live counter with the bits above the counter width at zero. Reading 0x08 returns control bits 7, 6 and 3 as written, with every other bit zero.
- R11: A 16-bit instance behaves the same as a 32-bit one within its width: load values are truncated to 16 bits and the wrap value is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after `bus_rd` |
| tick_fast | input | 1 | Fast tick enable, one-cycle pulses |
| tick_slow | input | 1 | Slow tick enable, one-cycle pulses |
| irq | output | 1 | Registered underflow interrupt, level |

## Verification
The countdown is driven with pulses on only the selected tick input, on only the input that is not selected, and on both inputs while counting is off. Together these show that the count follows the right enable and only that one. A short periodic load is run through two full periods to confirm the N+1 tick spacing and that the reload value is correct. A free-running run wraps both the 32-bit and the 16-bit instance, which separates a correct wrap to all ones from a reload and shows that the upper read bits are zero. The interrupt is acknowledged with zero data and with non-zero data, in the same cycle as an underflow, and by disabling the timer, so that each of its set and clear priorities is observed on its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register byte offsets
  localparam int OFS_LOAD  = 0;
  localparam int OFS_VALUE = 4;
  localparam int OFS_CTRL  = 8;
  localparam int OFS_CLEAR = 12;

  // Control word bit positions
  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]      cnt,
  output logic [CNT_W-1:0]      load_q,
  output tmr_pkg::tmr_ctrl_t    ctrl_q,
  output logic                  ld_wr,
  output logic                  clr_wr,
  output logic [DATA_W-1:0]     rdata_q
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

  logic              ctl_wr;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] ctl_view;
  logic              unused_wd;

  assign ld_wr     = bus_wr && (bus_addr == A_LOAD);
  assign ctl_wr    = bus_wr && (bus_addr == A_CTRL);
  assign clr_wr    = bus_wr && (bus_addr == A_CLEAR);
  assign unused_wd = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (ld_wr)
        load_q <= CNT_W'(bus_wdata);
      if (ctl_wr) begin
        ctrl_q.en       <= bus_wdata[CTL_EN];
        ctrl_q.periodic <= bus_wdata[CTL_PER];
        ctrl_q.fast     <= bus_wdata[CTL_FAST];
      end
    end
  end

  always_comb begin
    ctl_view           = '0;
    ctl_view[CTL_EN]   = ctrl_q.en;
    ctl_view[CTL_PER]  = ctrl_q.periodic;
    ctl_view[CTL_FAST] = ctrl_q.fast;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_LOAD)
      rd_mux = DATA_W'(load_q);
    else if (bus_addr == A_VALUE)
      rd_mux = DATA_W'(cnt);
    else if (bus_addr == A_CTRL)
      rd_mux = ctl_view;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rd_mux;
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld_wr |=> load_q == $past(CNT_W'(bus_wdata)));

  // R10
  value_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_VALUE) |=> rdata_q == DATA_W'($past(cnt)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             periodic,
  input  logic             tick,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_data,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf
);
  logic step;

  assign step = en && tick && !ld_wr;
  assign uf   = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld_wr)
      cnt_q <= ld_data;
    else if (step) begin
      if (cnt_q == '0)
        cnt_q <= periodic ? load_val : '1;
      else
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld_wr) |=> $stable(cnt_q));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !ld_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !ld_wr && periodic && cnt_q == '0) |=> cnt_q == $past(load_val));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !ld_wr && !periodic && cnt_q == '0) |=> (&cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uf,
  input  logic clr,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else if (!en)
      irq_q <= 1'b0;
    else if (uf)
      irq_q <= 1'b1;
    else if (clr)
      irq_q <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    uf |=> irq_q);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (en && clr && !uf) |=> !irq_q);

  // R9
  off_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  tmr_ctrl_t        ctrl_q;
  logic             ld_wr;
  logic             clr_wr;
  logic             tick_sel;
  logic             uf;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .load_q    (load_q),
    .ctrl_q    (ctrl_q),
    .ld_wr     (ld_wr),
    .clr_wr    (clr_wr),
    .rdata_q   (bus_rdata)
  );

  assign tick_sel = ctrl_q.fast ? tick_fast : tick_slow;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q.en),
    .periodic (ctrl_q.periodic),
    .tick     (tick_sel),
    .ld_wr    (ld_wr),
    .ld_data  (CNT_W'(bus_wdata)),
    .load_val (load_q),
    .cnt_q    (cnt_q),
    .uf       (uf)
  );

  tmr_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl_q.en),
    .uf    (uf),
    .clr   (clr_wr),
    .irq_q (irq)
  );
endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic        tf = 1'b0;
  logic        ts = 1'b0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer #(.CNT_W(32)) u0 (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata0), .tick_fast(tf), .tick_slow(ts),
    .irq(irq0));

  interval_timer #(.CNT_W(16)) u1 (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata1), .tick_fast(tf), .tick_slow(ts),
    .irq(irq1));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r0, output logic [31:0] r1);
    b_addr = a; b_rd = 1'b1;
    @(negedge clk);
    b_rd = 1'b0;
    r0 = rdata0; r1 = rdata1;
  endtask

  task automatic tick(input logic f, input logic s);
    tf = f; ts = s;
    @(negedge clk);
    tf = 1'b0; ts = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r0, r1;
    chk("R1", "irq after reset", {31'b0, irq0}, 32'h0);
    chk("R1", "rdata after reset", rdata0, 32'h0);
    rd(4'h4, r0, r1);
    chk("R1", "counter after reset", r0, 32'h0);
    rd(4'h8, r0, r1);
    chk("R1", "control after reset", r0, 32'h0);
    rd(4'h0, r0, r1);
    chk("R1", "load after reset", r0, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] r0, r1;
    wr(4'h0, 32'h1234_5678);
    rd(4'h4, r0, r1);
    chk("R2", "counter after load write", r0, 32'h1234_5678);
    chk("R11", "16-bit counter after load", r1, 32'h0000_5678);
    rd(4'h0, r0, r1);
    chk("R2", "load readback", r0, 32'h1234_5678);
    chk("R10", "16-bit load upper bits", r1, 32'h0000_5678);
  endtask

  task automatic t_disabled();
    logic [31:0] r0, r1;
    wr(4'h8, 32'h0000_0048);
    tick(1'b1, 1'b1); tick(1'b1, 1'b0); tick(1'b0, 1'b1);
    rd(4'h4, r0, r1);
    chk("R3", "counter held while off", r0, 32'h1234_5678);
    chk("R3", "no irq while off", {31'b0, irq0}, 32'h0);
    wr(4'h8, 32'h0000_00FF);
    rd(4'h8, r0, r1);
    chk("R10", "control readback masks", r0, 32'h0000_00C8);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_tick_select();
    logic [31:0] r0, r1;
    wr(4'h0, 32'd10);
    wr(4'h8, 32'h0000_0088);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    rd(4'h4, r0, r1);
    chk("R4", "slow ignored when fast selected", r0, 32'd10);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    rd(4'h4, r0, r1);
    chk("R4", "three fast ticks", r0, 32'd7);
    chk("R11", "16-bit three fast ticks", r1, 32'd7);
    wr(4'h8, 32'h0000_0080);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    rd(4'h4, r0, r1);
    chk("R4", "fast ignored when slow selected", r0, 32'd7);
    tick(1'b0, 1'b1);
    rd(4'h4, r0, r1);
    chk("R4", "one slow tick", r0, 32'd6);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] r0, r1;
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h0000_00C8);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk("R5", "no irq before underflow", {31'b0, irq0}, 32'h0);
    tick(1'b1, 1'b0);
    chk("R5", "irq on underflow", {31'b0, irq0}, 32'h1);
    rd(4'h4, r0, r1);
    chk("R5", "reloaded value", r0, 32'd2);
    wr(4'hC, 32'h0);
    chk("R7", "clear with zero data", {31'b0, irq0}, 32'h0);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk("R5", "second period not early", {31'b0, irq0}, 32'h0);
    tick(1'b1, 1'b0);
    chk("R5", "second period irq", {31'b0, irq0}, 32'h1);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_freerun();
    logic [31:0] r0, r1;
    wr(4'h0, 32'd1);
    wr(4'h8, 32'h0000_0088);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk("R6", "irq on wrap", {31'b0, irq0}, 32'h1);
    chk("R11", "16-bit irq on wrap", {31'b0, irq1}, 32'h1);
    rd(4'h4, r0, r1);
    chk("R6", "wrap to all ones", r0, 32'hFFFF_FFFF);
    chk("R11", "16-bit wrap value", r1, 32'h0000_FFFF);
    tick(1'b1, 1'b0);
    rd(4'h4, r0, r1);
    chk("R6", "continues after wrap", r0, 32'hFFFF_FFFE);
    chk("R10", "16-bit upper bits zero", r1, 32'h0000_FFFE);
    chk("R7", "irq sticky across ticks", {31'b0, irq0}, 32'h1);
    wr(4'hC, 32'hDEAD_BEEF);
    chk("R7", "clear with arbitrary data", {31'b0, irq0}, 32'h0);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_collide_and_disable();
    wr(4'h0, 32'd0);
    wr(4'h8, 32'h0000_00C8);
    b_addr = 4'hC; b_wdata = 32'h0; b_wr = 1'b1; tf = 1'b1;
    @(negedge clk);
    b_wr = 1'b0; tf = 1'b0;
    chk("R8", "underflow beats clear", {31'b0, irq0}, 32'h1);
    wr(4'hC, 32'h1);
    chk("R7", "clear alone", {31'b0, irq0}, 32'h0);
    tick(1'b1, 1'b0);
    chk("R5", "load zero fires every tick", {31'b0, irq0}, 32'h1);
    wr(4'h8, 32'h0);
    @(negedge clk);
    chk("R9", "disable drops irq", {31'b0, irq0}, 32'h0);
    chk("R9", "16-bit disable drops irq", {31'b0, irq1}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_disabled();
    t_tick_select();
    t_periodic();
    t_freerun();
    t_collide_and_disable();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule